// File: doc/BRIEF.md
# Extended-Address CPU Register File

This block stores the sixteen architectural registers of a microcontroller core that moves 16-bit data over a 20-bit address space. Register 0 is the program counter, register 1 the stack pointer, register 2 the 16-bit status register, and registers 4 to 15 are general purpose. Every register except the status register is 20 bits wide.

Two write paths update the file on the clock edge. The result path takes a value from the execution unit together with a size code and a sign-extend flag. The size code decides which upper bits are cleared. The pointer path adds a small unsigned step to a register, as an auto-increment addressing mode needs.

Two combinational read ports return the source and destination operands. On the source port, registers 2 and 3 double as constant generators. The 2-bit source addressing-mode field picks a fixed constant in place of the register contents.

Top module: `xrf_core`

## Requirements
- R1: After reset every register reads zero on the destination port.
- R2: A result write with size code 00 (byte) and the sign-extend flag clear stores data bits 7:0 and clears bits 19:8.
- R3: A result write with size code 01 (word) and the sign-extend flag clear stores data bits 15:0 and clears bits 19:16.
- R4: A result write with size code 10 or 11 (address-word) and the sign-extend flag clear stores all 20 data bits.
- R5: A result write with the sign-extend flag set stores data bits 7:0 and copies data bit 7 into bits 19:8, whatever the size code.
- R6: Register 2 keeps only 16 bits. Its bits 19:16 always read zero, on the destination port and on the source port with mode 00.
- R7: Registers 0 and 1 always hold bit 0 at zero, on both write paths.
- R8: A pointer write sets the register to its old 20-bit value plus the 3-bit unsigned step, wrapping modulo 2^20. The rules of R6 and R7 then apply to the sum.
- R9: When both write paths target the same register in one cycle, the result write is stored. When they target different registers, both are stored.
- R10: A source read of register 3 returns 0, 1, 2 or the all-ones constant for mode 00, 01, 10 and 11.
- R11: A source read of register 2 returns the status register for mode 00, zero for mode 01, 4 for mode 10 and 8 for mode 11.
- R12: The all-ones constant follows the source size code: 0xFF for 00, 0xFFFF for 01, and 0xFFFFF for 10 or 11.
- R13: The destination port, and the source port for any register other than 2 and 3, return the register contents and ignore the mode and size inputs.
- R14: Reads are combinational from the stored state. A write shows on the read ports after the clock edge that takes it, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_we | input | 1 | Result write enable |
| alu_idx | input | 4 | Result write register number |
| alu_size | input | 2 | Result size code: 00 byte, 01 word, 10/11 address-word |
| alu_sxt | input | 1 | Sign-extend bit 7 through bit 19 |
| alu_data | input | 20 | Result value |
| inc_we | input | 1 | Pointer write enable |
| inc_idx | input | 4 | Pointer register number |
| inc_step | input | 3 | Unsigned increment |
| src_idx | input | 4 | Source register number |
| src_mode | input | 2 | Source addressing-mode field |
| src_size | input | 2 | Source operation size code |
| src_data | output | 20 | Source operand or constant |
| dst_idx | input | 4 | Destination register number |
| dst_data | output | 20 | Destination register contents |

## Verification
The read ports are combinational, so a constant or a stored value can be checked a moment after the index and mode inputs settle, with no clock edge. A write is due exactly one rising edge after it is driven. The bench drives each write at a falling edge and drops the enable at the next falling edge. It then reads the register back through the destination port, so the single edge in between is the one that stores the write. One check reads just before that edge to confirm that the old value is still visible. The checker applies the same one-edge delay, using the previous cycle's write inputs against the current read outputs.

// File: rtl/xrf_pkg.sv
package xrf_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_ADDR = 2'b10,
        SZ_ADR2 = 2'b11
    } xrf_size_e;

    typedef enum logic [1:0] {
        MD_REG  = 2'b00,
        MD_IDX  = 2'b01,
        MD_IND  = 2'b10,
        MD_INC  = 2'b11
    } xrf_mode_e;

endpackage

// File: rtl/xrf_wr_fmt.sv
module xrf_wr_fmt #(
    parameter int AW = 20,
    parameter int DW = 16,
    parameter int BW = 8
) (
    input  logic [AW-1:0] data_i,
    input  logic [1:0]    size_i,
    input  logic          sxt_i,
    output logic [AW-1:0] value_o
);
    import xrf_pkg::*;

    always_comb begin
        if (sxt_i) begin
            value_o = {{(AW-BW){data_i[BW-1]}}, data_i[BW-1:0]};
        end else begin
            unique case (xrf_size_e'(size_i))
                SZ_BYTE: value_o = {{(AW-BW){1'b0}}, data_i[BW-1:0]};
                SZ_WORD: value_o = {{(AW-DW){1'b0}}, data_i[DW-1:0]};
                default: value_o = data_i;
            endcase
        end
    end

endmodule

// File: rtl/xrf_fit.sv
module xrf_fit #(
    parameter int AW     = 20,
    parameter int SRW    = 16,
    parameter int IW     = 4,
    parameter int PC_IDX = 0,
    parameter int SP_IDX = 1,
    parameter int SR_IDX = 2
) (
    input  logic [IW-1:0] idx_i,
    input  logic [AW-1:0] value_i,
    output logic [AW-1:0] value_o
);
    localparam logic [AW-1:0] SR_MASK = {{(AW-SRW){1'b0}}, {SRW{1'b1}}};

    always_comb begin
        value_o = value_i;
        if (idx_i == IW'(SR_IDX)) begin
            value_o = value_i & SR_MASK;
        end
        if (idx_i == IW'(PC_IDX) || idx_i == IW'(SP_IDX)) begin
            value_o[0] = 1'b0;
        end
    end

endmodule

// File: rtl/xrf_rd_port.sv
module xrf_rd_port #(
    parameter int AW      = 20,
    parameter int DW      = 16,
    parameter int BW      = 8,
    parameter int NREG    = 16,
    parameter int IW      = 4,
    parameter int CG1_IDX = 2,
    parameter int CG2_IDX = 3,
    parameter bit HAS_CG  = 1'b1
) (
    input  logic [NREG-1:0][AW-1:0] regs_i,
    input  logic [IW-1:0]           idx_i,
    input  logic [1:0]              mode_i,
    input  logic [1:0]              size_i,
    output logic [AW-1:0]           data_o
);
    import xrf_pkg::*;

    localparam logic [AW-1:0] ONES_B = {{(AW-BW){1'b0}}, {BW{1'b1}}};
    localparam logic [AW-1:0] ONES_W = {{(AW-DW){1'b0}}, {DW{1'b1}}};
    localparam logic [AW-1:0] ONES_A = {AW{1'b1}};

    logic [AW-1:0] ones_sized;
    logic          hit_cg1;
    logic          hit_cg2;

    always_comb begin
        unique case (xrf_size_e'(size_i))
            SZ_BYTE: ones_sized = ONES_B;
            SZ_WORD: ones_sized = ONES_W;
            default: ones_sized = ONES_A;
        endcase
    end

    assign hit_cg1 = HAS_CG && (idx_i == IW'(CG1_IDX));
    assign hit_cg2 = HAS_CG && (idx_i == IW'(CG2_IDX));

    always_comb begin
        data_o = regs_i[idx_i];
        if (hit_cg2) begin
            unique case (xrf_mode_e'(mode_i))
                MD_REG:  data_o = '0;
                MD_IDX:  data_o = AW'(1);
                MD_IND:  data_o = AW'(2);
                default: data_o = ones_sized;
            endcase
        end else if (hit_cg1) begin
            unique case (xrf_mode_e'(mode_i))
                MD_REG:  data_o = regs_i[idx_i];
                MD_IDX:  data_o = '0;
                MD_IND:  data_o = AW'(4);
                default: data_o = AW'(8);
            endcase
        end
    end

endmodule

// File: rtl/xrf_core.sv
module xrf_core #(
    parameter int AW     = 20,
    parameter int DW     = 16,
    parameter int BW     = 8,
    parameter int SRW    = 16,
    parameter int NREG   = 16,
    parameter int STEP_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      alu_we,
    input  logic [$clog2(NREG)-1:0]   alu_idx,
    input  logic [1:0]                alu_size,
    input  logic                      alu_sxt,
    input  logic [AW-1:0]             alu_data,
    input  logic                      inc_we,
    input  logic [$clog2(NREG)-1:0]   inc_idx,
    input  logic [STEP_W-1:0]         inc_step,
    input  logic [$clog2(NREG)-1:0]   src_idx,
    input  logic [1:0]                src_mode,
    input  logic [1:0]                src_size,
    output logic [AW-1:0]             src_data,
    input  logic [$clog2(NREG)-1:0]   dst_idx,
    output logic [AW-1:0]             dst_data
);
    localparam int IW      = $clog2(NREG);
    localparam int PC_IDX  = 0;
    localparam int SP_IDX  = 1;
    localparam int SR_IDX  = 2;
    localparam int CG2_IDX = 3;
    localparam int NPORT   = 2;

    typedef struct packed {
        logic [NREG-1:0][AW-1:0] regs;
    } xrf_state_t;

    xrf_state_t st_d;
    xrf_state_t st_q;

    logic [AW-1:0] alu_fmt;
    logic [AW-1:0] alu_fit;
    logic [AW-1:0] inc_sum;
    logic [AW-1:0] inc_fit;

    xrf_wr_fmt #(.AW(AW), .DW(DW), .BW(BW)) fmt_i (
        .data_i  (alu_data),
        .size_i  (alu_size),
        .sxt_i   (alu_sxt),
        .value_o (alu_fmt)
    );

    xrf_fit #(.AW(AW), .SRW(SRW), .IW(IW), .PC_IDX(PC_IDX),
              .SP_IDX(SP_IDX), .SR_IDX(SR_IDX)) fit_alu_i (
        .idx_i   (alu_idx),
        .value_i (alu_fmt),
        .value_o (alu_fit)
    );

    assign inc_sum = st_q.regs[inc_idx] + AW'(inc_step);

    xrf_fit #(.AW(AW), .SRW(SRW), .IW(IW), .PC_IDX(PC_IDX),
              .SP_IDX(SP_IDX), .SR_IDX(SR_IDX)) fit_inc_i (
        .idx_i   (inc_idx),
        .value_i (inc_sum),
        .value_o (inc_fit)
    );

    always_comb begin
        st_d = st_q;
        if (inc_we) begin
            st_d.regs[inc_idx] = inc_fit;
        end
        if (alu_we) begin
            st_d.regs[alu_idx] = alu_fit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic [NPORT-1:0][IW-1:0] rd_idx;
    logic [NPORT-1:0][AW-1:0] rd_data;

    assign rd_idx[0] = src_idx;
    assign rd_idx[1] = dst_idx;

    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        xrf_rd_port #(
            .AW(AW), .DW(DW), .BW(BW), .NREG(NREG), .IW(IW),
            .CG1_IDX(SR_IDX), .CG2_IDX(CG2_IDX), .HAS_CG(p == 0)
        ) port_i (
            .regs_i (st_q.regs),
            .idx_i  (rd_idx[p]),
            .mode_i (src_mode),
            .size_i (src_size),
            .data_o (rd_data[p])
        );
    end

    assign src_data = rd_data[0];
    assign dst_data = rd_data[1];

endmodule

// File: rtl/xrf_core_chk.sv
module xrf_core_chk #(
    parameter int AW     = 20,
    parameter int BW     = 8,
    parameter int SRW    = 16,
    parameter int NREG   = 16,
    parameter int STEP_W = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    alu_we,
    input logic [$clog2(NREG)-1:0] alu_idx,
    input logic [1:0]              alu_size,
    input logic                    alu_sxt,
    input logic [AW-1:0]           alu_data,
    input logic                    inc_we,
    input logic [$clog2(NREG)-1:0] inc_idx,
    input logic [STEP_W-1:0]       inc_step,
    input logic [$clog2(NREG)-1:0] src_idx,
    input logic [1:0]              src_mode,
    input logic [1:0]              src_size,
    input logic [AW-1:0]           src_data,
    input logic [$clog2(NREG)-1:0] dst_idx,
    input logic [AW-1:0]           dst_data
);
    localparam int IW = $clog2(NREG);

    // R6
    sr_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_idx == IW'(2)) |-> (dst_data[AW-1:SRW] == '0));

    // R7
    ptr_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_idx < IW'(2)) |-> (dst_data[0] == 1'b0));

    // R10
    cg_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_idx == IW'(3) && src_mode == 2'b01) |-> (src_data == AW'(1)));

    // R11
    cg_eight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_idx == IW'(2) && src_mode == 2'b11) |-> (src_data == AW'(8)));

    // R12
    cg_ones_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_idx == IW'(3) && src_mode == 2'b11 && src_size == 2'b00)
        |-> (src_data == {{(AW-BW){1'b0}}, {BW{1'b1}}}));

    // R2
    byte_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(alu_we) && $past(alu_size) == 2'b00 && !$past(alu_sxt)
         && dst_idx == $past(alu_idx))
        |-> (dst_data[AW-1:BW] == '0));

    // R4 and R9: the result path stores all bits even when the pointer path collides
    addr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(alu_we) && $past(alu_size) == 2'b10 && !$past(alu_sxt)
         && $past(alu_idx) >= IW'(4) && dst_idx == $past(alu_idx))
        |-> (dst_data == $past(alu_data)));

    // R5
    sxt_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(alu_we) && $past(alu_sxt) && $past(alu_idx) >= IW'(4)
         && dst_idx == $past(alu_idx))
        |-> (dst_data[AW-1:BW] == {(AW-BW){$past(alu_data[BW-1])}}));

endmodule

bind xrf_core xrf_core_chk chk_i (.*);

// File: tb/xrf_core_tb_top.sv
`timescale 1ns/1ps
module xrf_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alu_we = 1'b0;
    logic [3:0]  alu_idx = '0;
    logic [1:0]  alu_size = '0;
    logic        alu_sxt = 1'b0;
    logic [19:0] alu_data = '0;
    logic        inc_we = 1'b0;
    logic [3:0]  inc_idx = '0;
    logic [2:0]  inc_step = '0;
    logic [3:0]  src_idx = '0;
    logic [1:0]  src_mode = '0;
    logic [1:0]  src_size = '0;
    logic [19:0] src_data;
    logic [3:0]  dst_idx = '0;
    logic [19:0] dst_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [19:0] model [16];

    always #2.5 clk = ~clk;

    xrf_core dut_i (.*);

    task automatic check(string req, logic [19:0] act, logic [19:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%05h expected 0x%05h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] fit(int idx, logic [19:0] v);
        logic [19:0] r = v;
        if (idx == 2) r = r % 20'h10000;
        if (idx < 2) r = r - (r % 2);
        return r;
    endfunction

    function automatic logic [19:0] shape(int sz, bit sxt, logic [19:0] d);
        logic [19:0] lo = d % 256;
        if (sxt) return d[7] ? (20'hFFF00 + lo) : lo;
        if (sz == 0) return lo;
        if (sz == 1) return d % 20'h10000;
        return d;
    endfunction

    task automatic read_dst(int idx, string req);
        dst_idx = 4'(idx);
        #0.2;
        check(req, dst_data, model[idx]);
    endtask

    task automatic write_alu(int idx, int sz, bit sxt, logic [19:0] d);
        @(negedge clk);
        alu_we = 1'b1; alu_idx = 4'(idx); alu_size = 2'(sz);
        alu_sxt = sxt; alu_data = d;
        @(negedge clk);
        alu_we = 1'b0;
        model[idx] = fit(idx, shape(sz, sxt, d));
    endtask

    task automatic write_inc(int idx, int step);
        @(negedge clk);
        inc_we = 1'b1; inc_idx = 4'(idx); inc_step = 3'(step);
        @(negedge clk);
        inc_we = 1'b0;
        model[idx] = fit(idx, model[idx] + 20'(step));
    endtask

    function automatic logic [19:0] cg_exp(int idx, int md, int sz);
        logic [19:0] ones = (sz == 0) ? 20'hFF : (sz == 1) ? 20'hFFFF : 20'hFFFFF;
        if (idx == 3) return (md == 0) ? 20'h0 : (md == 1) ? 20'h1 : (md == 2) ? 20'h2 : ones;
        return (md == 0) ? model[2] : (md == 1) ? 20'h0 : (md == 2) ? 20'h4 : 20'h8;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: every register is zero after reset
        for (int i = 0; i < 16; i++) read_dst(i, "R1");

        // R2 R3 R4 R5 R6 R7: sweep every register, size code, sign flag and pattern
        for (int i = 0; i < 16; i++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int sx = 0; sx < 2; sx++) begin
                    for (int p = 0; p < 3; p++) begin
                        logic [19:0] d = (p == 0) ? 20'hA5F83 : (p == 1) ? 20'h5A07C : 20'hFFFFF;
                        string tag;
                        d = d ^ 20'(i * 20'h01111);
                        write_alu(i, sz, bit'(sx), d);
                        if (i == 2) tag = "R6";
                        else if (i < 2) tag = "R7";
                        else if (sx == 1) tag = "R5";
                        else if (sz == 0) tag = "R2";
                        else if (sz == 1) tag = "R3";
                        else tag = "R4";
                        read_dst(i, tag);
                    end
                end
            end
        end

        // R14: a write is not visible before its clock edge
        write_alu(9, 2, 1'b0, 20'h13579);
        @(negedge clk);
        alu_we = 1'b1; alu_idx = 4'd9; alu_size = 2'b10; alu_sxt = 1'b0; alu_data = 20'h2468A;
        dst_idx = 4'd9;
        #0.2;
        check("R14 before edge", dst_data, 20'h13579);
        @(negedge clk);
        alu_we = 1'b0;
        model[9] = 20'h2468A;
        read_dst(9, "R14 after edge");

        // R8: pointer increments on every register, including wrap and pointer/status rules
        for (int i = 0; i < 16; i++) begin
            write_alu(i, 2, 1'b0, 20'hFFFFD);
            for (int s = 1; s < 8; s = s * 2) begin
                write_inc(i, s);
                read_dst(i, "R8");
            end
        end

        // R9: same-register collision keeps the result write
        write_alu(7, 2, 1'b0, 20'h00100);
        @(negedge clk);
        alu_we = 1'b1; alu_idx = 4'd7; alu_size = 2'b10; alu_sxt = 1'b0; alu_data = 20'hABCDE;
        inc_we = 1'b1; inc_idx = 4'd7; inc_step = 3'd4;
        @(negedge clk);
        alu_we = 1'b0; inc_we = 1'b0;
        model[7] = 20'hABCDE;
        read_dst(7, "R9 same register");
        // R9: different registers both update
        write_alu(8, 2, 1'b0, 20'h00200);
        @(negedge clk);
        alu_we = 1'b1; alu_idx = 4'd7; alu_size = 2'b01; alu_sxt = 1'b0; alu_data = 20'h31234;
        inc_we = 1'b1; inc_idx = 4'd8; inc_step = 3'd2;
        @(negedge clk);
        alu_we = 1'b0; inc_we = 1'b0;
        model[7] = 20'h01234;
        model[8] = 20'h00202;
        read_dst(7, "R9 result path");
        read_dst(8, "R9 pointer path");

        // R10 R11 R12: constant generator sweep
        write_alu(2, 2, 1'b0, 20'hF8421);
        write_alu(3, 2, 1'b0, 20'h12345);
        for (int idx = 2; idx < 4; idx++) begin
            for (int md = 0; md < 4; md++) begin
                for (int sz = 0; sz < 4; sz++) begin
                    src_idx = 4'(idx); src_mode = 2'(md); src_size = 2'(sz);
                    #0.2;
                    if (idx == 3 && md == 3) check("R12", src_data, cg_exp(idx, md, sz));
                    else if (idx == 3) check("R10", src_data, cg_exp(idx, md, sz));
                    else check("R11", src_data, cg_exp(idx, md, sz));
                end
            end
        end

        // R13: destination port and ordinary source reads ignore mode and size
        read_dst(3, "R13 destination R3");
        read_dst(2, "R6 destination R2");
        write_alu(4, 2, 1'b0, 20'h9ABCD);
        for (int md = 0; md < 4; md++) begin
            src_idx = 4'd4; src_mode = 2'(md); src_size = 2'(md);
            #0.2;
            check("R13 source R4", src_data, model[4]);
        end

        finish_run();
    end

endmodule